// File: doc/BRIEF.md
# Multiplexed Address/Data Lane Steering Engine

This block connects a 32-bit internal master to a 32-bit pin bus that carries the address and the data on the same wires. A master hands over one 32-bit read or write together with an address, the width of the external device (8, 16 or 32 bits) and a lane-shift flag that selects which half of the bus a narrow device is wired to. The block splits the access into one, two or four bus cycles. Each bus cycle starts with one clock in which all 32 pins show the address of that cycle. A data clock follows, in which only the lanes that belong to the device carry data and byte enables.

In the data clock, pins that carry no data keep driving their address bits. For a write, the block drives the data lanes. For a read, it releases the data lanes, samples them at the end of the clock and places each byte into its position in a 32-bit result. After the last data clock it raises a one-cycle completion pulse, and the result is valid in that same cycle.

Top module: `muxbus_lane_steer`

## Requirements
- R1: After reset `reqReady` is 1, `done` is 0, `laneEn` is 0 and `padOe` is all zeros.
- R2: The clock after a request is accepted, and the first clock of every later bus cycle of the same access, is an address clock: `padOut` equals the address of that bus cycle, `padOe` is all ones and `laneEn` is 0.
- R3: The port size code sets the number of bus cycles: 2'b01 (8-bit) gives four, 2'b10 (16-bit) gives two, 2'b00 (32-bit) gives one. Each bus cycle is one address clock followed by one data clock.
- R4: The address of bus cycle k is the request address plus k times the port width in bytes (1 or 2). The 32-bit port uses the request address unchanged.
- R5: With lane shift 0, an 8-bit port uses lane 3 (pins 31:24) and a 16-bit port uses lanes 3:2 (pins 31:16).
- R6: With lane shift 1, an 8-bit port uses lane 0 (pins 7:0) and a 16-bit port uses lanes 1:0 (pins 15:0). A 32-bit port uses all four lanes, with byte i on lane i, whatever the shift setting.
- R7: Bytes go out most significant first. On an 8-bit port, bus cycle k carries byte 3-k of the word. On a 16-bit port, cycle 0 carries bytes 3:2 and cycle 1 carries bytes 1:0. Within a halfword, the upper byte is on the upper lane.
- R8: In a data clock, every lane without data drives the matching byte of that bus cycle's address, with its output enables high.
- R9: In a write data clock, all output enables are high and the data lanes carry the write bytes. In a read data clock, the output enables of the data lanes are low.
- R10: `done` is high for exactly one clock, the clock after the last data clock. For reads, `rdData` then holds every byte sampled from `padIn` on the data lanes, each at the byte position given by R7.
- R11: A request is accepted only while `reqReady` is high. `reqReady` is low from the clock after acceptance until the access completes. Size, shift, address, data and direction are captured at acceptance, so later changes on those inputs have no effect on the access.
- R12: `laneEn` has one bit per 8-bit lane (bit i for pins 8i+7:8i). A bit is high only in a data clock in which that lane carries data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 32 | Byte address of the access |
| reqWdata | input | 32 | Write word |
| reqPortSize | input | 2 | 00 = 32-bit, 01 = 8-bit, 10 = 16-bit |
| reqLaneShift | input | 1 | Narrow device on the low lanes when 1 |
| padIn | input | 32 | Sampled pin values |
| padOut | output | 32 | Pin drive values |
| padOe | output | 32 | Per-pin output enable |
| laneEn | output | 4 | Per-lane byte enable |
| rdData | output | 32 | Gathered read word, valid with done |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest behaviour to observe from the ports is the read gather. Each sampled byte must go to its proper position even though the physical lane is the same for every bus cycle on a narrow port. A wrong beat-to-byte order would be hidden if the pins held one value for the whole access. The stimulus therefore puts a different pattern on `padIn` in every address clock, for both shift settings and all three widths, and scrambles the request inputs right after acceptance. Any order, lane or capture-timing error then shows up in `rdData` at the completion pulse.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  typedef enum logic [1:0] {
    PS_WORD = 2'b00,
    PS_BYTE = 2'b01,
    PS_HALF = 2'b10,
    PS_RSVD = 2'b11
  } portSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       accept;
    logic       addrPhase;
    logic       dataPhase;
    logic [1:0] beatIdx;
  } steerCtl_t;

  // returns {active, byte index} for a given lane in a given beat
  function automatic logic [2:0] laneMap(portSize_e sz, logic shift,
                                         logic [1:0] beat, logic [1:0] lane);
    logic       act;
    logic [1:0] byteIdx;
    case (sz)
      PS_BYTE: begin
        act     = shift ? (lane == 2'd0) : (lane == 2'd3);
        byteIdx = ~beat;
      end
      PS_HALF: begin
        act     = shift ? (lane[1] == 1'b0) : (lane[1] == 1'b1);
        byteIdx = {~beat[0], lane[0]};
      end
      default: begin
        act     = 1'b1;
        byteIdx = lane;
      end
    endcase
    return {act, byteIdx};
  endfunction

endpackage

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqPortSize,
  output logic       reqReady,
  output steerCtl_t  ctl,
  output logic       done
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} state_e;

  state_e     state;
  logic [1:0] beatQ;
  logic [1:0] lastQ;
  logic       accept;
  logic [1:0] lastBeat;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    case (portSize_e'(reqPortSize))
      PS_BYTE: lastBeat = 2'd3;
      PS_HALF: lastBeat = 2'd1;
      default: lastBeat = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beatQ <= '0;
      lastQ <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_DATA) && (beatQ == lastQ);
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_ADDR;
          beatQ <= '0;
          lastQ <= lastBeat;
        end
        ST_ADDR: state <= ST_DATA;
        ST_DATA: begin
          if (beatQ == lastQ) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_ADDR;
            beatQ <= beatQ + 2'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.accept    = accept;
    ctl.addrPhase = (state == ST_ADDR);
    ctl.dataPhase = (state == ST_DATA);
    ctl.beatIdx   = beatQ;
  end

endmodule

// File: rtl/muxbus_datapath.sv
module muxbus_datapath
  import muxbus_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  steerCtl_t        ctl,
  input  logic             reqWrite,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic [1:0]       reqPortSize,
  input  logic             reqLaneShift,
  input  logic [BUS_W-1:0] padIn,
  output logic [BUS_W-1:0] padOut,
  output logic [BUS_W-1:0] padOe,
  output logic [BUS_W/8-1:0] laneEn,
  output logic [BUS_W-1:0] rdData
);

  localparam int LANES = BUS_W / 8;

  logic [BUS_W-1:0] addrQ;
  logic [BUS_W-1:0] wdataQ;
  portSize_e        sizeQ;
  logic             shiftQ;
  logic             writeQ;
  logic [BUS_W-1:0] rdAccQ;
  logic [BUS_W-1:0] beatAddr;
  logic [LANES-1:0] laneAct;
  logic [1:0]       laneByte [LANES];
  logic             busy;

  assign busy = ctl.addrPhase || ctl.dataPhase;

  always_comb begin
    case (sizeQ)
      PS_BYTE: beatAddr = addrQ + BUS_W'(ctl.beatIdx);
      PS_HALF: beatAddr = addrQ + BUS_W'({ctl.beatIdx, 1'b0});
      default: beatAddr = addrQ;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [2:0] map;
    logic       dataLane;
    assign map         = laneMap(sizeQ, shiftQ, ctl.beatIdx, 2'(l));
    assign laneAct[l]  = map[2];
    assign laneByte[l] = map[1:0];
    assign dataLane    = ctl.dataPhase && map[2];
    assign laneEn[l]   = dataLane;
    assign padOut[8*l +: 8] = !busy ? 8'h00 :
                              (dataLane && writeQ) ? wdataQ[8*map[1:0] +: 8] :
                              beatAddr[8*l +: 8];
    assign padOe[8*l +: 8]  = {8{busy && !(dataLane && !writeQ)}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      sizeQ  <= PS_WORD;
      shiftQ <= 1'b0;
      writeQ <= 1'b0;
      rdAccQ <= '0;
    end else if (ctl.accept) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      sizeQ  <= portSize_e'(reqPortSize);
      shiftQ <= reqLaneShift;
      writeQ <= reqWrite;
      rdAccQ <= '0;
    end else if (ctl.dataPhase && !writeQ) begin
      for (int l = 0; l < LANES; l++) begin
        if (laneAct[l]) rdAccQ[8*laneByte[l] +: 8] <= padIn[8*l +: 8];
      end
    end
  end

  assign rdData = rdAccQ;

endmodule

// File: rtl/muxbus_lane_steer.sv
module muxbus_lane_steer
  import muxbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic [1:0]  reqPortSize,
  input  logic        reqLaneShift,
  input  logic [31:0] padIn,
  output logic [31:0] padOut,
  output logic [31:0] padOe,
  output logic [3:0]  laneEn,
  output logic [31:0] rdData,
  output logic        done
);

  steerCtl_t ctl;

  muxbus_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqPortSize (reqPortSize),
    .reqReady    (reqReady),
    .ctl         (ctl),
    .done        (done)
  );

  muxbus_datapath #(.BUS_W(32)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqWrite     (reqWrite),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .reqPortSize  (reqPortSize),
    .reqLaneShift (reqLaneShift),
    .padIn        (padIn),
    .padOut       (padOut),
    .padOe        (padOe),
    .laneEn       (laneEn),
    .rdData       (rdData)
  );

endmodule

// File: rtl/muxbus_chk.sv
module muxbus_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqAddr,
  input logic [31:0] padOut,
  input logic [31:0] padOe,
  input logic [3:0]  laneEn,
  input logic        done
);

  // R2: acceptance is followed by a full address clock
  a_r2_addr_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (padOe == 32'hFFFF_FFFF && laneEn == 4'b0 &&
                                padOut == $past(reqAddr)));

  // R3: every data clock is preceded by an address clock
  a_r3_data_after_addr: assert property (@(posedge clk) disable iff (!rstN)
    (laneEn != 4'b0) |-> ($past(laneEn) == 4'b0 && $past(padOe) == 32'hFFFF_FFFF));

  // R12: only 1, 2 or 4 lanes may be enabled at once
  a_r12_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(laneEn) != 3));

  // R9: released pins are exactly the enabled lanes during a read data clock
  a_r9_read_release: assert property (@(posedge clk) disable iff (!rstN)
    (laneEn != 4'b0 && padOe != 32'hFFFF_FFFF) |->
      (padOe == {{8{~laneEn[3]}}, {8{~laneEn[2]}}, {8{~laneEn[1]}}, {8{~laneEn[0]}}}));

  // R10: completion is a single-clock pulse following a data clock
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_done_after_data: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(laneEn) != 4'b0 && reqReady));

  // R11: ready drops after acceptance; idle means no lane activity
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (laneEn == 4'b0 && padOe == 32'b0));

endmodule

bind muxbus_lane_steer muxbus_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqAddr  (reqAddr),
  .padOut   (padOut),
  .padOe    (padOe),
  .laneEn   (laneEn),
  .done     (done)
);

// File: tb/muxbus_lane_steer_tb.sv
`timescale 1ns/1ps
module muxbus_lane_steer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [1:0]  reqPortSize = '0;
  logic        reqLaneShift = 1'b0;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic [3:0]  laneEn;
  logic [31:0] rdData;
  logic        done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          isAddr;
    logic [31:0] out;
    logic [31:0] oe;
    logic [3:0]  en;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  muxbus_lane_steer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqPortSize(reqPortSize), .reqLaneShift(reqLaneShift), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .laneEn(laneEn), .rdData(rdData), .done(done)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every active pin cycle is compared against the scoreboard
  always @(negedge clk) begin
    if (rstN && !finished && (padOe != 32'b0 || laneEn != 4'b0)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected bus activity", padOe, 32'b0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.isAddr) begin
          check(padOut == e.out, "R2 R4 address clock padOut", padOut, e.out);
          check(padOe == e.oe && laneEn == e.en, "R2 address clock oe/en",
                {padOe[27:0], laneEn}, {e.oe[27:0], e.en});
        end else begin
          check(laneEn == e.en, "R5 R6 R7 R12 laneEn", 32'(laneEn), 32'(e.en));
          check(padOut == e.out, "R7 R8 R9 data clock padOut", padOut, e.out);
          check(padOe == e.oe, "R8 R9 data clock padOe", padOe, e.oe);
        end
      end
    end
  end

  function automatic logic [31:0] pinPattern(int k, logic [31:0] addr);
    return 32'h1F2E_3D4C ^ (32'h0101_0101 * (k + 3)) ^ {addr[7:0], addr[15:8], addr[23:16], addr[31:24]};
  endfunction

  task automatic runReq(bit wr, logic [1:0] sz, bit sh, logic [31:0] addr, logic [31:0] wdata);
    int nb;
    int w;
    logic [31:0] expRd;
    logic [31:0] pins [4];
    nb = (sz == 2'b01) ? 4 : (sz == 2'b10) ? 2 : 1;
    w  = 4 / nb;
    expRd = '0;
    for (int k = 0; k < nb; k++) begin
      expItem_t a;
      expItem_t d;
      logic [31:0] ba;
      pins[k] = pinPattern(k, addr);
      ba = addr + 32'(k * w);
      a.isAddr = 1'b1; a.out = ba; a.oe = '1; a.en = '0;
      d.isAddr = 1'b0; d.out = ba; d.oe = '1; d.en = '0;
      for (int j = 0; j < w; j++) begin
        int b;
        int lane;
        b = 3 - k * w - j;
        if (nb == 1)      lane = b;
        else if (nb == 2) lane = (sh ? 0 : 2) + (b % 2);
        else              lane = sh ? 0 : 3;
        d.en[lane] = 1'b1;
        if (wr) d.out[lane*8 +: 8] = wdata[b*8 +: 8];
        else    d.oe[lane*8 +: 8]  = 8'h00;
        expRd[b*8 +: 8] = pins[k][lane*8 +: 8];
      end
      expQ.push_back(a);
      expQ.push_back(d);
    end
    // drive request
    reqValid = 1'b1; reqWrite = wr; reqPortSize = sz; reqLaneShift = sh;
    reqAddr = addr; reqWdata = wdata;
    check(reqReady == 1'b1, "R11 ready before request", 32'(reqReady), 32'd1);
    @(posedge clk);
    @(negedge clk);
    // scramble request inputs: must have no effect (R11)
    reqValid = 1'b0; reqPortSize = ~sz; reqLaneShift = ~sh;
    reqAddr = ~addr; reqWdata = ~wdata; reqWrite = ~wr;
    check(reqReady == 1'b0, "R11 ready low while busy", 32'(reqReady), 32'd0);
    for (int k = 0; k < nb; k++) begin
      if (k > 0) @(negedge clk);
      padIn = pins[k];
      @(negedge clk);
      check(done == 1'b0, "R3 R10 no done during data clock", 32'(done), 32'd0);
    end
    @(negedge clk);
    check(done == 1'b1, "R3 R10 done after last data clock", 32'(done), 32'd1);
    if (!wr) check(rdData == expRd, "R7 R10 gathered read word", rdData, expRd);
    padIn = 32'hDEAD_BEEF;
  endtask

  initial begin
    #(5 * 20000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during and after reset
    check(reqReady == 1'b1 && done == 1'b0, "R1 reset ready/done", {30'b0, reqReady, done}, 32'd2);
    check(padOe == 32'b0 && laneEn == 4'b0, "R1 reset pins quiet", padOe | 32'(laneEn), 32'b0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && padOe == 32'b0, "R1 idle after reset", {31'b0, reqReady}, 32'd1);
    // R3 R5 R6: writes across sizes and shift settings
    runReq(1'b1, 2'b01, 1'b0, 32'h4000_1000, 32'hA1B2_C3D4);
    runReq(1'b1, 2'b01, 1'b1, 32'h4000_2004, 32'h1122_3344);
    runReq(1'b1, 2'b10, 1'b0, 32'h6000_0010, 32'h5566_7788);
    runReq(1'b1, 2'b10, 1'b1, 32'h6000_0020, 32'h99AA_BBCC);
    runReq(1'b1, 2'b00, 1'b0, 32'h8000_0100, 32'hCAFE_F00D);
    runReq(1'b1, 2'b00, 1'b1, 32'h8000_0200, 32'h0BAD_1DEA);
    // R10: reads, back to back after completion
    runReq(1'b0, 2'b01, 1'b0, 32'h2000_0300, 32'h0);
    runReq(1'b0, 2'b01, 1'b1, 32'h2000_0400, 32'h0);
    runReq(1'b0, 2'b10, 1'b0, 32'h2000_0500, 32'h0);
    runReq(1'b0, 2'b10, 1'b1, 32'h2000_0600, 32'h0);
    runReq(1'b0, 2'b00, 1'b1, 32'h2000_0700, 32'h0);
    // R4: address increment carrying across a byte boundary
    runReq(1'b0, 2'b01, 1'b0, 32'h0000_00FE, 32'h0);
    runReq(1'b1, 2'b10, 1'b1, 32'h0000_FFFE, 32'h1357_9BDF);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 all expected clocks observed", 32'(expQ.size()), 32'd0);
    check(done == 1'b0 && reqReady == 1'b1, "R10 R11 idle at end", {30'b0, done, reqReady}, 32'd1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule